// File: doc/BRIEF.md
# System Clock Gear Controller

This block sits beside a small microcontroller core. It turns a free-running oscillator into a single-cycle clock enable for the CPU and its peripherals. Software picks one of four speed gears through a byte-wide control register. The gears divide the oscillator by 4, 8, 16 or 64. A second enable feeds the time-base timer. It ignores the gear and asserts on every oscillator cycle except while the oscillator is stopped.

The block also sequences low-power stop. A stop request taken in active mode halts both enables. An external-interrupt wake then starts an oscillation-stabilization wait, and the CPU enable stays low until that wait has counted down. Software chooses the length of the wait through a two-bit field. The reset value of that field is a build-time parameter, and the same optioned wait is applied when reset is released. A read-only monitor bit tells software whether the clock is running or still settling. Some register bits read as fixed values and ignore writes.

Top module: `gear_clk_ctl`

## Requirements
- R1: While running, `cpu_ce` is a one-cycle pulse repeating every 4, 8, 16 or 64 clocks for gear field (bits 1:0) values 2'b11, 2'b10, 2'b01 and 2'b00 respectively.
- R2: After reset, the register reads monitor 0, bits 4:3 = `WT_RST`, gear 2'b00. The monitor reads 1, and `cpu_ce` may pulse, only once the wait selected by `WT_RST` has elapsed: `WAIT_n` clocks after reset is released.
- R3: Bit 7 reads 1 when running and 0 when stopped or settling; values written to it are ignored.
- R4: Bits 6 and 5 always read 0 and bit 2 always reads 1, whatever is written.
- R5: `stop_req` while running stops the block at the next edge: monitor, `cpu_ce` and `tb_ce` stay 0 until a wake; `stop_req` has no effect unless running.
- R6: `ext_wake` while stopped starts a wait; `ext_wake` while running has no effect.
- R7: Writes to the wait field (bits 4:3) are accepted at any time, including during a wait, and read back at once; a wait already in progress keeps its length and the new code applies at the next wake.
- R8: After the wake edge, the monitor reads 1 following `WAIT0`, `WAIT1`, `WAIT2` or `WAIT3` clocks for wait codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R9: A gear write takes effect at the next `cpu_ce` pulse of the old gear, so no interval is shortened or doubled.
- R10: `tb_ce` is 1 on every clock while not stopped (settling or running), independent of the gear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| stop_req | input | 1 | Request to enter stop |
| ext_wake | input | 1 | External-interrupt wake from stop |
| cpu_ce | output | 1 | Geared CPU/peripheral clock enable |
| tb_ce | output | 1 | Time-base clock enable, ungeared |

## Verification
The bench shrinks the stabilization counts to 3, 5, 9 and 12 clocks and sets the reset wait code to 2'b10. With those values, every wait code and the optioned post-reset wait can each be timed to the exact cycle within a short run. The divider keeps its real ratios, so gear intervals up to 64 clocks, and a gear change landing mid-interval, are measured at full scale.

// File: rtl/gear_clk_ctl.sv
module gear_clk_ctl #(
  parameter logic [1:0] WT_RST = 2'b11,
  parameter int WAIT0 = 16,
  parameter int WAIT1 = 1024,
  parameter int WAIT2 = 16384,
  parameter int WAIT3 = 131072,
  parameter int CNT_W = 17
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       stop_req,
  input  logic       ext_wake,
  output logic       cpu_ce,
  output logic       tb_ce
);

  typedef enum logic [1:0] {S_ACT, S_STOP, S_WAIT} st_t;

  function automatic logic [CNT_W-1:0] wait_len(input logic [1:0] c);
    case (c)
      2'b00:   return CNT_W'(WAIT0 - 1);
      2'b01:   return CNT_W'(WAIT1 - 1);
      2'b10:   return CNT_W'(WAIT2 - 1);
      default: return CNT_W'(WAIT3 - 1);
    endcase
  endfunction

  function automatic logic [5:0] gear_lim(input logic [1:0] g);
    case (g)
      2'b11:   return 6'd3;
      2'b10:   return 6'd7;
      2'b01:   return 6'd15;
      default: return 6'd63;
    endcase
  endfunction

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       cs, wt, cur_gear;
  logic [5:0]       dcnt;
  logic             mon, tick;

  assign mon       = (state == S_ACT);
  assign tick      = mon && (dcnt == gear_lim(cur_gear));
  assign cpu_ce    = tick;
  assign tb_ce     = (state != S_STOP);
  assign reg_rdata = {mon, 2'b00, wt, 1'b1, cs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs <= 2'b00;
      wt <= WT_RST;
    end else if (reg_wr) begin
      cs <= reg_wdata[1:0];
      wt <= reg_wdata[4:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_WAIT;
      cnt   <= wait_len(WT_RST);
    end else begin
      case (state)
        S_ACT:  if (stop_req) state <= S_STOP;
        S_STOP: if (ext_wake) begin
          state <= S_WAIT;
          cnt   <= wait_len(wt);
        end
        default: begin
          if (cnt == '0) state <= S_ACT;
          else           cnt   <= cnt - 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt     <= '0;
      cur_gear <= 2'b00;
    end else if (!mon || tick) begin
      dcnt     <= '0;
      cur_gear <= cs;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  AST_CE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |=> !cpu_ce); // R1
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && !ext_wake) |=> (state == S_STOP && !tb_ce)); // R5
  AST_WAKE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STOP && ext_wake) |=> (state == S_WAIT && cnt == wait_len($past(wt)))); // R6
  AST_WAIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && cnt != '0) |=> (state == S_WAIT && cnt == $past(cnt) - 1'b1)); // R8
  AST_GEAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mon && !tick) |=> (cur_gear == $past(cur_gear))); // R9

endmodule

// File: tb/gear_clk_ctl_tb_top.sv
module gear_clk_ctl_tb_top;
  localparam int W0 = 3, W1 = 5, W2 = 9, W3 = 12;
  localparam logic [1:0] WTR = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, stop_req = 1'b0, ext_wake = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic cpu_ce, tb_ce;

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  bit armed = 1'b0;
  int gap = 0;

  gear_clk_ctl #(.WT_RST(WTR), .WAIT0(W0), .WAIT1(W1), .WAIT2(W2), .WAIT3(W3), .CNT_W(17)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stop_req(stop_req), .ext_wake(ext_wake), .cpu_ce(cpu_ce), .tb_ce(tb_ce));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    gap++;
    if (cpu_ce === 1'b1) begin
      if (armed && exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(gap == e, t, gap, e);
      end
      armed = 1'b1;
      gap = 0;
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [7:0] cfg(input logic [1:0] w, input logic [1:0] g);
    return {3'b000, w, 1'b0, g};
  endfunction

  task automatic run_gear(input logic [1:0] w, input logic [1:0] g, input int ratio);
    wr(cfg(w, g));
    @(posedge clk);
    armed = 1'b0;
    repeat (3) begin exp_q.push_back(ratio); tag_q.push_back("R1"); end
    while (exp_q.size() != 0) @(negedge clk);
    chk(tb_ce == 1'b1, "R10", tb_ce, 1);
  endtask

  task automatic do_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic wake_measure(input int exp_n, input string req);
    int n;
    @(negedge clk); ext_wake = 1'b1;
    @(negedge clk); ext_wake = 1'b0;
    n = 1;
    chk(tb_ce == 1'b1, "R10", tb_ce, 1);
    while (reg_rdata[7] !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    chk(n == exp_n + 1, req, n, exp_n + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, pulses;
    repeat (3) @(negedge clk);
    chk(reg_rdata == {1'b0, 2'b00, WTR, 1'b1, 2'b00}, "R2", reg_rdata, {1'b0, 2'b00, WTR, 1'b1, 2'b00});
    rst_n = 1'b1;
    n = 0; pulses = 0;
    while (reg_rdata[7] !== 1'b1 && n < 100) begin
      if (cpu_ce) pulses++;
      @(negedge clk); n++;
    end
    chk(n == W2, "R2", n, W2);
    chk(pulses == 0, "R2", pulses, 0);
    chk(reg_rdata == 8'h94, "R3", reg_rdata, 8'h94);

    wr(8'h64);
    chk(reg_rdata == 8'h84, "R4", reg_rdata, 8'h84);
    wr(8'h03);
    chk(reg_rdata == 8'h87, "R3", reg_rdata, 8'h87);

    run_gear(2'b00, 2'b11, 4);
    run_gear(2'b00, 2'b10, 8);
    run_gear(2'b00, 2'b01, 16);
    run_gear(2'b00, 2'b00, 64);

    @(posedge clk);
    armed = 1'b0;
    exp_q.push_back(64); tag_q.push_back("R9");
    exp_q.push_back(4);  tag_q.push_back("R9");
    exp_q.push_back(4);  tag_q.push_back("R9");
    do @(negedge clk); while (cpu_ce !== 1'b1);
    repeat (5) @(negedge clk);
    reg_wr = 1'b1; reg_wdata = cfg(2'b00, 2'b11);
    @(negedge clk); reg_wr = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);

    @(negedge clk); ext_wake = 1'b1;
    @(negedge clk); ext_wake = 1'b0;
    chk(reg_rdata[7] == 1'b1, "R6", reg_rdata[7], 1);

    do_stop();
    chk(reg_rdata[7] == 1'b0, "R5", reg_rdata[7], 0);
    chk(tb_ce == 1'b0, "R5", tb_ce, 0);
    wr(8'h80 | cfg(2'b00, 2'b11));
    chk(reg_rdata[7] == 1'b0, "R3", reg_rdata[7], 0);
    pulses = 0;
    stop_req = 1'b1;
    repeat (40) begin @(negedge clk); if (cpu_ce || tb_ce) pulses++; end
    stop_req = 1'b0;
    chk(pulses == 0, "R5", pulses, 0);

    @(negedge clk); ext_wake = 1'b1;
    @(negedge clk); ext_wake = 1'b0;
    reg_wr = 1'b1; reg_wdata = cfg(2'b11, 2'b11);
    @(negedge clk); reg_wr = 1'b0;
    n = 2;
    chk(reg_rdata[4:3] == 2'b11, "R7", reg_rdata[4:3], 3);
    while (reg_rdata[7] !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    chk(n == W0 + 1, "R7", n, W0 + 1);

    do_stop();
    wake_measure(W3, "R8");
    wr(cfg(2'b01, 2'b11));
    do_stop();
    wake_measure(W1, "R8");
    wr(cfg(2'b10, 2'b11));
    do_stop();
    wake_measure(W2, "R8");
    wr(cfg(2'b00, 2'b10));
    do_stop();
    wake_measure(W0, "R6");
    run_gear(2'b00, 2'b10, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule